// File: doc/BRIEF.md
# Table-Indexed SPI Serial Clock Generator

This block derives an SPI serial clock, together with one-cycle strobes that mark its leading and trailing edges, from the system clock. A 5-bit index picks the divide ratio from a fixed ladder that alternates powers of two with three-times-powers-of-two: 3, 4, 6, 8, 12, 16, 24 and so on up to 1024. The shift engine next to it uses the leading strobe to launch data and the trailing strobe to capture it.

Index 0 is reserved and parks the clock at its idle level. The divide-by-3 step is only usable while a special-mode input is set. A parameter caps the usable index at 16 or 18, and larger requests are clamped. The ratio is latched at period boundaries, so changing the index never produces a shortened pulse. A run input lets the clock advance or holds it in place. A stop input sends it back to idle and clears its position.

Top module: `spi_sclk_gen`

## Requirements
- R1: For an index i from 2 up to the cap, the serial clock period is D(i) system cycles. D(i) is 2·2^(i/2) for even i and 3·2^((i-1)/2) for odd i (4, 6, 8, 12 … 1024). The period is measured from one leading strobe to the next.
- R2: While index 0 is in effect, the serial clock stays at its idle level and neither strobe is raised.
- R3: Index 1 gives a 3-cycle period while special_en is 1. While special_en is 0, index 1 behaves exactly like index 2 (4 cycles).
- R4: An index above MAX_IDX (default 18) is treated as MAX_IDX. Index 31 therefore gives a 1024-cycle period by default.
- R5: Each period starts with the active phase, which lasts floor(N/2) cycles, and ends with the idle phase, which lasts ceil(N/2) cycles. With N = 3 that is 1 active cycle and 2 idle cycles.
- R6: The idle level of sclk equals cpol and the active level is its inverse. Out of reset sclk equals cpol and both strobes are 0.
- R7: A new index is sampled only at the last cycle of the current period. The period already in progress completes at its old length.
- R8: All outputs are registered and change at the clock edge that samples the inputs. lead_stb is high for exactly the cycle in which sclk enters the active level, and trail_stb for exactly the cycle in which it returns to idle.
- R9: stop overrides run. At the next edge sclk goes to idle, the strobes drop and the position clears, so the next run starts a full period with a leading strobe at its first edge.
- R10: While run is 0 and stop is 0, sclk holds its level, no strobe is raised, and the period resumes where it stopped once run returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_idx | input | 5 | Divide-ratio index |
| special_en | input | 1 | Permits the divide-by-3 index |
| cpol | input | 1 | Idle level of sclk |
| run | input | 1 | Advance the serial clock when 1 |
| stop | input | 1 | Return to idle and clear the position |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe on entry to the active level |
| trail_stb | output | 1 | One-cycle strobe on return to idle |

## Verification
The edge-strobe checks assume that cpol stays constant while the clock is live. A polarity flip in mid-period would move sclk without a strobe and would break the link between a strobe and a level change. The stimulus changes cpol only while stop is asserted. All inputs are driven on the falling clock edge, so every rising edge sees them settled. Index changes, pauses and stops are placed deliberately in mid-period to reach the boundary, hold and restart cases.

// File: rtl/spi_sclk_pkg.sv
// Shared widths and the divide-ratio ladder for the serial clock generator.
// Assumes the index never exceeds 18 after clamping (largest ratio 1024).
package spi_sclk_pkg;
    localparam int IDX_W = 5;
    localparam int DIV_W = 11;

    // Ratio for an index: 0 reserved, 1 -> 3, even i -> 2<<(i/2), odd i -> 3<<(i/2).
    function automatic logic [DIV_W-1:0] ratio_of(input logic [IDX_W-1:0] i);
        logic [DIV_W-1:0] r;
        if (i == '0)
            r = '0;
        else if (i == IDX_W'(1))
            r = DIV_W'(3);
        else if (!i[0])
            r = DIV_W'(2) << (i >> 1);
        else
            r = DIV_W'(3) << (i >> 1);
        return r;
    endfunction
endpackage

// File: rtl/spi_ratio_select.sv
// Turns the requested index into an effective divide ratio.
// Clamps to MAX_IDX and folds index 1 onto index 2 unless special mode is on.
// Purely combinational; assumes MAX_IDX is 16 or 18.
module spi_ratio_select
    import spi_sclk_pkg::*;
#(
    parameter int MAX_IDX = 18
) (
    input  logic [IDX_W-1:0] idx_in,
    input  logic             special_en,
    output logic [DIV_W-1:0] ratio_out
);
    localparam logic [IDX_W-1:0] IDX_CAP = IDX_W'(MAX_IDX);

    logic [IDX_W-1:0] idx_clamped;
    logic [IDX_W-1:0] idx_eff;

    // Limit the index, then replace an unpermitted divide-by-3 with divide-by-4.
    always_comb begin
        idx_clamped = (idx_in > IDX_CAP) ? IDX_CAP : idx_in;
        idx_eff     = idx_clamped;
        if (idx_clamped == IDX_W'(1) && !special_en)
            idx_eff = IDX_W'(2);
        ratio_out = ratio_of(idx_eff);
    end
endmodule

// File: rtl/spi_period_counter.sv
// Tracks the position inside the current serial clock period and the ratio
// latched for it. A new ratio is taken only at a period boundary, on stop,
// or while not live. Outputs are the next-state values for the edge shaper.
module spi_period_counter
    import spi_sclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             stop,
    input  logic [DIV_W-1:0] ratio_req,
    output logic             live_nx,
    output logic             adv_nx,
    output logic [DIV_W-1:0] pos_nx,
    output logic [DIV_W-1:0] ratio_nx
);
    logic             live_q;
    logic [DIV_W-1:0] pos_q;
    logic [DIV_W-1:0] ratio_q;
    logic             at_end;

    assign at_end = (pos_q == ratio_q - 1'b1);

    // Next position, ratio and liveness from run/stop and the period boundary.
    always_comb begin
        live_nx  = live_q;
        pos_nx   = pos_q;
        ratio_nx = ratio_q;
        adv_nx   = 1'b0;
        if (stop) begin
            live_nx  = 1'b0;
            pos_nx   = '0;
            ratio_nx = ratio_req;
        end else if (run) begin
            if (!live_q || at_end) begin
                ratio_nx = ratio_req;
                pos_nx   = '0;
                live_nx  = (ratio_req != '0);
                adv_nx   = (ratio_req != '0);
            end else begin
                pos_nx = pos_q + 1'b1;
                adv_nx = 1'b1;
            end
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q  <= 1'b0;
            pos_q   <= '0;
            ratio_q <= '0;
        end else begin
            live_q  <= live_nx;
            pos_q   <= pos_nx;
            ratio_q <= ratio_nx;
        end
    end

    // R1
    pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (pos_q < ratio_q));

    // R7
    ratio_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !at_end && !stop) |=> $stable(ratio_q));

    // R9
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!live_q && pos_q == '0));
endmodule

// File: rtl/spi_edge_shaper.sv
// Registers sclk and the two edge strobes from the counter's next state, so
// every output is glitch-free and aligned to the same system-clock edge.
// Assumes cpol is steady while the clock is live.
module spi_edge_shaper
    import spi_sclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpol,
    input  logic             live_nx,
    input  logic             adv_nx,
    input  logic [DIV_W-1:0] pos_nx,
    input  logic [DIV_W-1:0] ratio_nx,
    output logic             sclk,
    output logic             lead_stb,
    output logic             trail_stb
);
    logic [DIV_W-1:0] half_nx;
    logic             active_nx;

    assign half_nx   = ratio_nx >> 1;
    assign active_nx = live_nx && (pos_nx < half_nx);

    // Output registers: level from the phase, strobes on phase entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk      <= cpol;
            lead_stb  <= 1'b0;
            trail_stb <= 1'b0;
        end else begin
            sclk      <= active_nx ? ~cpol : cpol;
            lead_stb  <= adv_nx && (pos_nx == '0);
            trail_stb <= adv_nx && (pos_nx == half_nx);
        end
    end

    // R8
    lead_moves_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |-> (sclk != $past(sclk)));

    // R8
    trail_moves_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |-> (sclk != $past(sclk)));

    // R8
    strobes_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_stb && trail_stb));
endmodule

// File: rtl/spi_sclk_gen.sv
// Top of the table-indexed serial clock generator: ratio selection, period
// counter and edge shaper. Assumes MAX_IDX is 16 or 18 and that inputs are
// synchronous to clk.
module spi_sclk_gen
    import spi_sclk_pkg::*;
#(
    parameter int MAX_IDX = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] div_idx,
    input  logic             special_en,
    input  logic             cpol,
    input  logic             run,
    input  logic             stop,
    output logic             sclk,
    output logic             lead_stb,
    output logic             trail_stb
);
    logic [DIV_W-1:0] ratio_sel;
    logic             live_nx;
    logic             adv_nx;
    logic [DIV_W-1:0] pos_nx;
    logic [DIV_W-1:0] ratio_nx;

    spi_ratio_select #(.MAX_IDX(MAX_IDX)) u_select (
        .idx_in     (div_idx),
        .special_en (special_en),
        .ratio_out  (ratio_sel)
    );

    spi_period_counter u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .stop      (stop),
        .ratio_req (ratio_sel),
        .live_nx   (live_nx),
        .adv_nx    (adv_nx),
        .pos_nx    (pos_nx),
        .ratio_nx  (ratio_nx)
    );

    spi_edge_shaper u_shaper (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpol      (cpol),
        .live_nx   (live_nx),
        .adv_nx    (adv_nx),
        .pos_nx    (pos_nx),
        .ratio_nx  (ratio_nx),
        .sclk      (sclk),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );

    // R3
    div3_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_sel == DIV_W'(3)) |-> special_en);

    // R4
    ratio_capped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_sel <= ratio_of(IDX_W'(MAX_IDX)));

    // R2
    idle_index_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_sel == '0 && !lead_stb && sclk == cpol && run && !stop) |=> !lead_stb);
endmodule

// File: tb/spi_sclk_gen_test.sv
module spi_sclk_gen_test;
    localparam int MAXI = 18;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] div_idx = 5'd0;
    logic       special_en = 1'b0;
    logic       cpol = 1'b0;
    logic       run = 1'b0;
    logic       stop = 1'b0;
    logic       sclk, lead_stb, trail_stb;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string cur_req = "R6";
    int tbl [0:18];
    int lead_seen = 0;

    // behavioural reference state
    int  m_live, m_pos, m_div, req_div, e_idx;
    bit  m_sclk, m_lead, m_trail;

    spi_sclk_gen #(.MAX_IDX(MAXI)) uut (
        .clk(clk), .rst_n(rst_n), .div_idx(div_idx), .special_en(special_en),
        .cpol(cpol), .run(run), .stop(stop),
        .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
    );

    always #4 clk = ~clk;

    initial begin
        tbl[0] = 0; tbl[1] = 3; tbl[2] = 4; tbl[3] = 6;
        for (int i = 4; i <= 18; i++) tbl[i] = tbl[i-2] * 2;
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // reference model, one step per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_live = 0; m_pos = 0; m_div = 0; m_sclk = cpol; m_lead = 0; m_trail = 0;
        end else begin
            e_idx = div_idx;
            if (e_idx > MAXI) e_idx = MAXI;
            if (e_idx == 1 && !special_en) e_idx = 2;
            req_div = tbl[e_idx];
            m_lead = 0; m_trail = 0;
            if (stop) begin
                m_live = 0; m_pos = 0; m_div = req_div;
            end else if (run) begin
                if (m_live == 0 || m_pos == m_div - 1) begin
                    m_div = req_div; m_pos = 0; m_live = (req_div != 0);
                    m_lead = (m_live != 0);
                end else begin
                    m_pos++;
                    m_trail = (m_pos == m_div / 2);
                end
            end
            m_sclk = (m_live != 0 && m_pos < m_div / 2) ? !cpol : cpol;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(cur_req, sclk, m_sclk, "sclk vs model");
            check(cur_req, lead_stb, m_lead, "lead vs model");
            check(cur_req, trail_stb, m_trail, "trail vs model");
            if (lead_stb) lead_seen++;
        end
    end

    task automatic wait_lead();
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (lead_stb) return;
        end
    endtask

    // measure one period from a leading strobe to the next
    task automatic measure(input string req, input int exp_n);
        int n, act;
        wait_lead();
        n = 0; act = 1;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (lead_stb) break;
            n++;
            if (sclk != cpol) act++;
        end
        n++;
        check(req, n, exp_n, "period");
        check(req, act, exp_n / 2, "active cycles");
    endtask

    initial begin
        int n;
        bit held;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R6";
        check("R6", sclk, 0, "reset sclk");
        check("R6", lead_stb, 0, "reset lead");
        check("R6", trail_stb, 0, "reset trail");

        // R2: reserved index
        cur_req = "R2";
        div_idx = 5'd0; run = 1'b1;
        lead_seen = 0;
        repeat (30) @(negedge clk);
        check("R2", lead_seen, 0, "leads at index 0");
        check("R2", sclk, 0, "sclk at index 0");

        // R3 / R5: divide by 3 with special mode
        cur_req = "R3";
        special_en = 1'b1; div_idx = 5'd1;
        measure("R3", 3);
        measure("R5", 3);
        special_en = 1'b0;
        measure("R3", 4);

        // R1: whole ladder
        cur_req = "R1";
        for (int i = 2; i <= MAXI; i++) begin
            div_idx = 5'(i);
            measure("R1", tbl[i]);
        end

        // R4: clamp
        cur_req = "R4";
        div_idx = 5'd31;
        measure("R4", 1024);

        // R7: change of index in mid-period
        cur_req = "R7";
        div_idx = 5'd6;
        measure("R7", 16);
        n = 1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (lead_stb) break;
            n++;
            if (n == 3) div_idx = 5'd2;
        end
        check("R7", n, 16, "old period completes");
        measure("R7", 4);

        // R9: stop in mid-period overrides run
        cur_req = "R9";
        div_idx = 5'd4;
        wait_lead();
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        check("R9", sclk, 0, "sclk idle after stop");
        check("R9", lead_stb + trail_stb, 0, "no strobes on stop");
        cpol = 1'b1;
        @(negedge clk);
        check("R6", sclk, 1, "idle follows cpol");
        stop = 1'b0;
        @(negedge clk);
        check("R9", lead_stb, 1, "lead on first edge after stop");
        check("R6", sclk, 0, "active level inverse of cpol");

        // R6: full period with cpol high
        cur_req = "R6";
        measure("R6", 8);

        // R10: pause holds
        cur_req = "R10";
        wait_lead();
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        held = sclk;
        lead_seen = 0;
        n = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (sclk != held || trail_stb) n++;
        end
        check("R10", n, 0, "changes while paused");
        check("R10", lead_seen, 0, "leads while paused");
        run = 1'b1;
        measure("R10", 8);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule